// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block collects the interrupt requests of a small 8-bit processor and reduces them to one interrupt request line and one wake-up line. Four kinds of source feed it. The first is an external pin that the block samples and checks for edges. The second is a one-cycle timer overflow pulse. The third is a one-cycle port-change pulse. The fourth is a parameterised group of peripheral event pulses. Each source sets a sticky flag. A flag stays set until software writes a zero to it.

Enabling works on two levels. Each source has its own enable bit. The peripheral group also has a group enable. A global enable gates only the request to the processor. The wake-up line ignores the global enable, so a sleeping core can resume without taking the vector. The vector address output is a fixed constant. Software reaches the state through a small synchronous write port with a combinational read-back, organised as four byte-wide registers:

- Address 0 is the control register.
- Address 1 holds the peripheral flags.
- Address 2 holds the peripheral enables.
- Address 3 holds the options.

Top module: `irq_aggregator`

## Requirements
- R1: The option register bit 0 selects the edge of the external pin. A value of 1 selects rising and 0 selects falling. The edge that is not selected never sets the external flag. A pin change made just after clock edge k shows in the external flag (control bit 5) after edge k+3 and not before.
- R2: Each selected edge on the external pin sets the external flag exactly once, whatever the value of the external enable (control bit 2).
- R3: The flags do not clear by themselves. A set flag stays set until a write to its register puts a 0 in its bit position.
- R4: A pulse on `tmr_ovf` sets the timer flag (control bit 6) at the next clock edge. The timer enable is control bit 3.
- R5: A pulse on `port_chg` sets the port flag (control bit 7) at the next clock edge. The port enable is control bit 4.
- R6: A pulse on `per_evt[i]` sets bit i of the peripheral flag register (address 1). The peripheral group counts as pending only when some flag bit and the same bit of the peripheral enable register (address 2) are both 1 and the group enable (control bit 1) is 1.
- R7: `irq` is 1 exactly when the global enable (control bit 0) is 1 and at least one source is pending.
- R8: `wake` is 1 exactly when at least one source is pending, whatever the value of the global enable.
- R9: A hardware set and a software write of 0 to the same flag in the same cycle leave the flag set.
- R10: Writing a new edge selection while the pin is steady never sets the external flag.
- R11: `vector` always equals 0x0004.
- R12: The registers reset to zero and read back what was written. Option bits 7 to 1 read as 0. Addresses above 3 do not exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | One-cycle timer rollover pulse |
| port_chg | input | 1 | One-cycle port-change pulse |
| per_evt | input | NPERIPH | One-cycle peripheral event pulses |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request, independent of the global enable |
| vector | output | PC_W | Fixed interrupt vector address |

## Verification
The assertions check the following on every cycle:

- Every hardware event lands in its flag one cycle later.
- Flags stay set when no write reaches their register.
- An edge detect lasts only one cycle.
- `irq` never rises without `wake`.

Only the bench scenarios can show the rest: the three-edge latency of the pin, the rejection of the edge that is not selected, the quiet change of the edge selection, and the exact truth table of the two enable levels with their read-back values.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ADDR_W = 2;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_PFLAG = 2'd1;
   localparam logic [ADDR_W-1:0] A_PEN   = 2'd2;
   localparam logic [ADDR_W-1:0] A_OPT   = 2'd3;

   // control register bit positions
   localparam int B_GLB   = 0;
   localparam int B_PGRP  = 1;
   localparam int B_EXTEN = 2;
   localparam int B_TMREN = 3;
   localparam int B_PRTEN = 4;
   localparam int B_EXTF  = 5;
   localparam int B_TMRF  = 6;
   localparam int B_PRTF  = 7;

   // index of each core flag inside the flag bank
   localparam int F_EXT = 0;
   localparam int F_TMR = 1;
   localparam int F_PRT = 2;
   localparam int NCORE = 3;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic hit
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] chain;
   logic                   prev;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("irq_edge_detect: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[LAST];

   // compares only consecutive samples; rise_sel picks the direction
   always_comb begin
      if (rise_sel) hit = chain[LAST] & ~prev;
      else          hit = ~chain[LAST] & prev;
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hw_set,
   input  logic         sw_wr,
   input  logic [W-1:0] sw_data,
   output logic [W-1:0] flags
);
   generate
      if (W < 1) begin : g_bad
         $error("irq_flag_bank: W must be positive");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags[i] <= 1'b0;
            else if (hw_set[i]) flags[i] <= 1'b1;   // set beats clear
            else if (sw_wr)    flags[i] <= sw_data[i];
         end
      end
   endgenerate
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int NPERIPH = 8
) (
   input  logic               glb_en,
   input  logic               grp_en,
   input  logic               ext_en,
   input  logic               ext_f,
   input  logic               tmr_en,
   input  logic               tmr_f,
   input  logic               prt_en,
   input  logic               prt_f,
   input  logic [NPERIPH-1:0] p_en,
   input  logic [NPERIPH-1:0] p_f,
   output logic               pending,
   output logic               req
);
   logic [NPERIPH-1:0] p_hit;
   logic               grp_any;

   generate
      for (genvar i = 0; i < NPERIPH; i++) begin : g_and
         assign p_hit[i] = p_en[i] & p_f[i];
      end
   endgenerate

   assign grp_any = grp_en & (|p_hit);
   assign pending = (ext_en & ext_f) | (tmr_en & tmr_f) | (prt_en & prt_f) | grp_any;
   assign req     = glb_en & pending;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NPERIPH     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PC_W        = 13,
   parameter int VEC_ADDR    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_pin,
   input  logic                tmr_ovf,
   input  logic                port_chg,
   input  logic [NPERIPH-1:0]  per_evt,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq,
   output logic                wake,
   output logic [PC_W-1:0]     vector
);
   localparam int PAD = DATA_W - NPERIPH;

   generate
      if (NPERIPH < 1 || NPERIPH > DATA_W) begin : g_bad_np
         $error("irq_aggregator: NPERIPH must lie in 1..DATA_W");
      end
      if (VEC_ADDR < 0 || VEC_ADDR >= (1 << PC_W)) begin : g_bad_vec
         $error("irq_aggregator: VEC_ADDR does not fit in PC_W");
      end
   endgenerate

   logic               wr_ctrl, wr_pflag, wr_pen, wr_opt;
   logic               glb_en, grp_en, ext_en, tmr_en, prt_en, rise_sel;
   logic [NPERIPH-1:0] pen_q, pflags;
   logic [NCORE-1:0]   core_set, core_wdata, ctrl_flags;
   logic               ext_hit;

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign wr_pflag = reg_wr && (reg_addr == A_PFLAG);
   assign wr_pen   = reg_wr && (reg_addr == A_PEN);
   assign wr_opt   = reg_wr && (reg_addr == A_OPT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en   <= 1'b0;
         grp_en   <= 1'b0;
         ext_en   <= 1'b0;
         tmr_en   <= 1'b0;
         prt_en   <= 1'b0;
         pen_q    <= '0;
         rise_sel <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            glb_en <= reg_wdata[B_GLB];
            grp_en <= reg_wdata[B_PGRP];
            ext_en <= reg_wdata[B_EXTEN];
            tmr_en <= reg_wdata[B_TMREN];
            prt_en <= reg_wdata[B_PRTEN];
         end
         if (wr_pen) pen_q    <= reg_wdata[NPERIPH-1:0];
         if (wr_opt) rise_sel <= reg_wdata[0];
      end
   end

   irq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(rise_sel), .hit(ext_hit)
   );

   assign core_set[F_EXT]   = ext_hit;
   assign core_set[F_TMR]   = tmr_ovf;
   assign core_set[F_PRT]   = port_chg;
   assign core_wdata[F_EXT] = reg_wdata[B_EXTF];
   assign core_wdata[F_TMR] = reg_wdata[B_TMRF];
   assign core_wdata[F_PRT] = reg_wdata[B_PRTF];

   irq_flag_bank #(.W(NCORE)) u_core_flags (
      .clk(clk), .rst_n(rst_n), .hw_set(core_set), .sw_wr(wr_ctrl),
      .sw_data(core_wdata), .flags(ctrl_flags)
   );

   irq_flag_bank #(.W(NPERIPH)) u_per_flags (
      .clk(clk), .rst_n(rst_n), .hw_set(per_evt), .sw_wr(wr_pflag),
      .sw_data(reg_wdata[NPERIPH-1:0]), .flags(pflags)
   );

   irq_combine #(.NPERIPH(NPERIPH)) u_comb (
      .glb_en(glb_en), .grp_en(grp_en),
      .ext_en(ext_en), .ext_f(ctrl_flags[F_EXT]),
      .tmr_en(tmr_en), .tmr_f(ctrl_flags[F_TMR]),
      .prt_en(prt_en), .prt_f(ctrl_flags[F_PRT]),
      .p_en(pen_q), .p_f(pflags),
      .pending(wake), .req(irq)
   );

   logic [DATA_W-1:0] ctrl_view, pflag_view, pen_view;

   always_comb begin
      ctrl_view          = '0;
      ctrl_view[B_GLB]   = glb_en;
      ctrl_view[B_PGRP]  = grp_en;
      ctrl_view[B_EXTEN] = ext_en;
      ctrl_view[B_TMREN] = tmr_en;
      ctrl_view[B_PRTEN] = prt_en;
      ctrl_view[B_EXTF]  = ctrl_flags[F_EXT];
      ctrl_view[B_TMRF]  = ctrl_flags[F_TMR];
      ctrl_view[B_PRTF]  = ctrl_flags[F_PRT];
   end

   generate
      if (PAD > 0) begin : g_pad
         assign pflag_view = {{PAD{1'b0}}, pflags};
         assign pen_view   = {{PAD{1'b0}}, pen_q};
      end else begin : g_nopad
         assign pflag_view = pflags;
         assign pen_view   = pen_q;
      end
   endgenerate

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = ctrl_view;
         A_PFLAG: reg_rdata = pflag_view;
         A_PEN:   reg_rdata = pen_view;
         default: reg_rdata = {{(DATA_W-1){1'b0}}, rise_sel};
      endcase
   end

   assign vector = PC_W'(VEC_ADDR);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
   import irq_agg_pkg::*;
#(
   parameter int NPERIPH = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               tmr_ovf,
   input logic               port_chg,
   input logic [NPERIPH-1:0] per_evt,
   input logic               ext_hit,
   input logic [NCORE-1:0]   ctrl_flags,
   input logic [NPERIPH-1:0] pflags,
   input logic               irq,
   input logic               wake
);
   logic ctrl_wr;
   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

   // R2: one selected edge gives a single detect pulse
   p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ext_hit |=> !ext_hit);

   // R3: the external flag holds without a control write
   p_ext_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_flags[F_EXT] && !ctrl_wr) |=> ctrl_flags[F_EXT]);

   // R4: a timer pulse reaches its flag one cycle later
   p_tmr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |=> ctrl_flags[F_TMR]);

   // R5: a port-change pulse reaches its flag one cycle later
   p_prt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      port_chg |=> ctrl_flags[F_PRT]);

   // R6: every peripheral event bit lands in its flag
   p_per_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|per_evt) |=> ((pflags & $past(per_evt)) == $past(per_evt)));

   // R9: an edge detect wins over a clear in the same cycle
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_hit |=> ctrl_flags[F_EXT]);

   // R7, R8: the request to the core implies the wake line
   p_irq_has_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> wake);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NPERIPH(NPERIPH)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .tmr_ovf(tmr_ovf), .port_chg(port_chg), .per_evt(per_evt),
   .ext_hit(ext_hit), .ctrl_flags(ctrl_flags), .pflags(pflags),
   .irq(irq), .wake(wake)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_pin = 1'b0;
   logic          tmr_ovf = 1'b0;
   logic          port_chg = 1'b0;
   logic [NP-1:0] per_evt = '0;
   logic [1:0]    reg_addr = 2'd0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          irq, wake;
   logic [12:0]   vector;

   always #4 clk = ~clk;

   irq_aggregator u_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
      .port_chg(port_chg), .per_evt(per_evt), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .wake(wake), .vector(vector)
   );

   typedef enum logic [1:0] {K_RD, K_IRQ, K_WAKE, K_VEC} kind_t;
   typedef struct {
      kind_t kind;
      int    exp;
      string req;
   } item_t;

   item_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         int act;
         it = q.pop_front();
         case (it.kind)
            K_RD:    act = int'(reg_rdata);
            K_IRQ:   act = int'(irq);
            K_WAKE:  act = int'(wake);
            default: act = int'(vector);
         endcase
         n_chk++;
         if (act != it.exp) begin
            n_fail++;
            $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(kind_t k, int e, string r);
      item_t it;
      it.kind = k; it.exp = e; it.req = r;
      q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic expect_reg(logic [1:0] a, int e, string r);
      reg_addr = a;
      push(K_RD, e, r);
   endtask

   task automatic expect_lines(int ei, int ew, string r);
      push(K_IRQ, ei, r);
      push(K_WAKE, ew, r);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick(1);
      reg_wr = 1'b0;
   endtask

   initial begin
      tick(2);
      rst_n = 1'b1;
      tick(1);
      // R12 / R11: reset state
      expect_reg(2'd0, 8'h00, "R12 ctrl reset");
      expect_reg(2'd1, 8'h00, "R12 pflag reset");
      expect_reg(2'd2, 8'h00, "R12 pen reset");
      expect_reg(2'd3, 8'h00, "R12 opt reset");
      expect_lines(0, 0, "R7 R8 idle after reset");
      push(K_VEC, 4, "R11 vector");

      // R1, R2: rising edge, latency of three edges, enable clear
      wr(2'd3, 8'h01);
      ext_pin = 1'b1;
      tick(2);
      expect_reg(2'd0, 8'h00, "R1 flag not yet set");
      tick(1);
      expect_reg(2'd0, 8'h20, "R2 rising edge sets flag with enable off");
      expect_lines(0, 0, "R8 disabled source no wake");
      tick(5);
      expect_reg(2'd0, 8'h20, "R3 flag sticky");
      wr(2'd0, 8'h00);
      expect_reg(2'd0, 8'h00, "R3 software clear");

      // R1: falling edge ignored while rising is selected
      ext_pin = 1'b0;
      tick(4);
      expect_reg(2'd0, 8'h00, "R1 falling ignored in rising mode");

      // R10: reselecting the edge on a steady pin
      wr(2'd3, 8'h00);
      tick(4);
      expect_reg(2'd0, 8'h00, "R10 no detect on select change low");
      ext_pin = 1'b1;
      tick(4);
      expect_reg(2'd0, 8'h00, "R1 rising ignored in falling mode");
      wr(2'd3, 8'h01);
      tick(4);
      expect_reg(2'd0, 8'h00, "R10 no detect on select change high");
      wr(2'd3, 8'h00);
      ext_pin = 1'b0;
      tick(4);
      expect_reg(2'd0, 8'h20, "R1 falling edge sets flag");
      wr(2'd0, 8'h24);
      expect_lines(0, 1, "R8 ext pending without global");
      wr(2'd0, 8'h00);

      // R4, R7, R8: timer source
      tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
      expect_reg(2'd0, 8'h40, "R4 timer flag set");
      expect_lines(0, 0, "R8 timer disabled");
      wr(2'd0, 8'h48);
      expect_lines(0, 1, "R8 wake without global");
      wr(2'd0, 8'h49);
      expect_lines(1, 1, "R7 irq with global");
      wr(2'd0, 8'h09);
      expect_lines(0, 0, "R3 R7 clear drops irq");

      // R5: port-change source
      port_chg = 1'b1; tick(1); port_chg = 1'b0;
      expect_reg(2'd0, 8'h89, "R5 port flag set");
      expect_lines(0, 0, "R5 port disabled no request");
      wr(2'd0, 8'h91);
      expect_lines(1, 1, "R5 R7 port enabled");
      wr(2'd0, 8'h11);

      // R6: peripheral group, two-level gating
      wr(2'd2, 8'h04);
      per_evt = 8'h04; tick(1); per_evt = '0;
      expect_reg(2'd1, 8'h04, "R6 peripheral flag set");
      expect_lines(0, 0, "R6 group disabled");
      wr(2'd0, 8'h02);
      expect_lines(0, 1, "R6 R8 group wake without global");
      wr(2'd0, 8'h03);
      expect_lines(1, 1, "R6 R7 group irq");
      per_evt = 8'h08; tick(1); per_evt = '0;
      expect_reg(2'd1, 8'h0C, "R6 second peripheral flag");
      wr(2'd1, 8'h08);
      expect_reg(2'd1, 8'h08, "R3 selective peripheral clear");
      expect_lines(0, 0, "R6 unenabled flag not pending");

      // R9: set wins over clear in the same cycle
      per_evt = 8'h01;
      wr(2'd1, 8'h00);
      per_evt = '0;
      expect_reg(2'd1, 8'h01, "R9 peripheral set beats clear");
      tmr_ovf = 1'b1;
      wr(2'd0, 8'h00);
      tmr_ovf = 1'b0;
      expect_reg(2'd0, 8'h40, "R9 timer set beats clear");

      // R12: readback widths
      wr(2'd3, 8'hFF);
      expect_reg(2'd3, 8'h01, "R12 option readback");
      wr(2'd2, 8'hA5);
      expect_reg(2'd2, 8'hA5, "R12 enable readback");
      push(K_VEC, 4, "R11 vector steady");

      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule